// File: doc/BRIEF.md
# Nibble-Encoded Two-Byte Register Processor

This block is a small multicycle processor core. It has sixteen 8-bit general registers and an 8-bit program counter. It executes a seven-instruction set from a byte-wide single-port synchronous memory. Every instruction is two bytes long. The high nibble of the first byte selects the operation and the low nibble names the destination or test register Rn. The second byte holds an address, an immediate or a branch offset. For the register-to-register forms, the high nibble of the second byte names the source register Rm.

The core has three kinds of instruction: moves between registers and memory, 8-bit add and subtract, and one conditional branch. The branch tests a register for zero and, when the register is zero, moves the program counter by a signed offset. Any opcode outside the defined set stops the core for good, until the next reset.

A debug read port shows any register at any time. An integrating environment can use it to inspect results after the core halts.

Top module: `nib_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the core presents address 0 with no write and halt low. Every register reads 0 through the debug port while reset is high.
- R2: Each instruction is read as two bytes, from PC and then PC+1, with the write enable low during both reads. The high nibble of the first byte is the opcode, its low nibble is Rn, and the high nibble of the second byte is Rm.
- R3: Opcode 3 copies the second byte into Rn.
- R4: Opcode 4 sets Rn to Rn+Rm and opcode 5 sets Rn to Rn-Rm, both modulo 256.
- R5: Opcode 0 loads Rn from the memory address given by the second byte.
- R6: Opcode 1 writes Rn to the memory address given by the second byte.
- R7: Opcode 2 writes Rm to the memory address held in Rn.
- R8: Opcode 8 adds the second byte, as a two's-complement value, to the address of the following instruction when Rn is zero. When Rn is not zero, execution falls through to the next instruction.
- R9: Any other opcode (6, 7, 9 to 15) sets the halt output. Halt stays high until reset. While halted, the core performs no write, changes no register and holds its address.
- R10: Opcodes 3, 4, 5, 8 and undefined opcodes take 3 clock cycles. Opcodes 0, 1 and 2 take 4 clock cycles.
- R11: The debug port returns the register chosen by the debug select input combinationally, in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once an undefined opcode has executed |
| dbg_sel | input | 4 | Register index for the debug port |
| dbg_val | output | 8 | Contents of the selected register |

## Verification
Two cases are hard to reach from the ports.

The first is a backward branch that is taken. It needs a zero-test register and a negative offset that lands on code already passed over, without looping forever. The stimulus therefore jumps forward over a block, falls through a not-taken test, and then branches back into the skipped block, which ends in a halt.

The second is a register-indirect store whose address register was itself produced by an earlier immediate load. It is checked through the scoreboard of expected memory writes. The wrap of add and subtract past 255 and below 0 is also checked, with chosen operands whose results are visible on the debug port after halt.

// File: rtl/nib_pkg.sv
package nib_pkg;

    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int NREG  = 16;
    localparam int RW    = $clog2(NREG);
    localparam int OPW   = 4;

    typedef enum logic [2:0] {
        PH_F1,
        PH_F2,
        PH_EX,
        PH_MEM,
        PH_HALT
    } phase_e;

    typedef enum logic [2:0] {
        K_LD,
        K_ST,
        K_STI,
        K_LI,
        K_ADD,
        K_SUB,
        K_BZ,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e          kind;
        logic [RW-1:0]  rn;
        logic [RW-1:0]  rm;
        logic [DW-1:0]  arg;
    } dec_t;

    function automatic logic [DW-1:0] alu_fn(input logic sub,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
        return sub ? (a - b) : (a + b);
    endfunction

endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_pkg::*;
(
    input  logic [DW-1:0] byte0,
    input  logic [DW-1:0] byte1,
    output dec_t          dec
);
    always_comb begin
        dec.rn  = byte0[RW-1:0];
        dec.rm  = byte1[DW-1 -: RW];
        dec.arg = byte1;
        case (byte0[DW-1 -: OPW])
            4'h0:    dec.kind = K_LD;
            4'h1:    dec.kind = K_ST;
            4'h2:    dec.kind = K_STI;
            4'h3:    dec.kind = K_LI;
            4'h4:    dec.kind = K_ADD;
            4'h5:    dec.kind = K_SUB;
            4'h8:    dec.kind = K_BZ;
            default: dec.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
    import nib_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [RW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    input  logic [RW-1:0] rc,
    output logic [DW-1:0] qa,
    output logic [DW-1:0] qb,
    output logic [DW-1:0] qc
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];
    assign qc = regs[rc];
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_pkg::*;
(
    input  logic          sub,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    assign y = alu_fn(sub, a, b);
endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted,
    input  logic [RW-1:0] dbg_sel,
    output logic [DW-1:0] dbg_val
);
    phase_e        phase, phase_d;
    logic [AW-1:0] pc, pc_d;
    logic [DW-1:0] ir0, ir1;
    logic [DW-1:0] byte1;
    dec_t          dec;
    logic [DW-1:0] rd_a, rd_b, alu_y;
    logic          rf_we;
    logic [DW-1:0] rf_wd;

    // In execute the second byte is still on the read bus; later it comes from ir1.
    assign byte1 = (phase == PH_EX) ? mem_rdata : ir1;

    nib_decode u_dec (
        .byte0 (ir0),
        .byte1 (byte1),
        .dec   (dec)
    );

    nib_regfile u_rf (
        .clk (clk),
        .rst (rst),
        .we  (rf_we),
        .wa  (dec.rn),
        .wd  (rf_wd),
        .ra  (dec.rn),
        .rb  (dec.rm),
        .rc  (dbg_sel),
        .qa  (rd_a),
        .qb  (rd_b),
        .qc  (dbg_val)
    );

    nib_alu u_alu (
        .sub (dec.kind == K_SUB),
        .a   (rd_a),
        .b   (rd_b),
        .y   (alu_y)
    );

    always_comb begin
        phase_d   = phase;
        pc_d      = pc;
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = '0;
        rf_we     = 1'b0;
        rf_wd     = alu_y;
        case (phase)
            PH_F1: begin
                pc_d    = pc + 1'b1;
                phase_d = PH_F2;
            end
            PH_F2: begin
                pc_d    = pc + 1'b1;
                phase_d = PH_EX;
            end
            PH_EX: begin
                phase_d = PH_F1;
                case (dec.kind)
                    K_LI: begin
                        rf_we = 1'b1;
                        rf_wd = dec.arg;
                    end
                    K_ADD, K_SUB: rf_we = 1'b1;
                    K_BZ: if (rd_a == '0) pc_d = pc + dec.arg;
                    K_LD: begin
                        mem_addr = dec.arg;
                        phase_d  = PH_MEM;
                    end
                    K_ST, K_STI: phase_d = PH_MEM;
                    default: phase_d = PH_HALT;
                endcase
            end
            PH_MEM: begin
                phase_d = PH_F1;
                case (dec.kind)
                    K_LD: begin
                        rf_we = 1'b1;
                        rf_wd = mem_rdata;
                    end
                    K_ST: begin
                        mem_addr  = dec.arg;
                        mem_we    = 1'b1;
                        mem_wdata = rd_a;
                    end
                    K_STI: begin
                        mem_addr  = rd_a;
                        mem_we    = 1'b1;
                        mem_wdata = rd_b;
                    end
                    default: ;
                endcase
            end
            default: phase_d = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_F1;
            pc    <= '0;
            ir0   <= '0;
            ir1   <= '0;
        end else begin
            phase <= phase_d;
            pc    <= pc_d;
            if (phase == PH_F2) ir0 <= mem_rdata;
            if (phase == PH_EX) ir1 <= mem_rdata;
        end
    end

    assign halted = (phase == PH_HALT);
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk
    import nib_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          halted,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input phase_e        phase
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: first cycle out of reset fetches from address 0
    always @(posedge clk) begin
        if (rst_q && !rst) begin
            a_r1_fetch_zero: assert (mem_addr == '0 && !mem_we && !halted)
                else $error("R1 start state wrong");
        end
    end

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> (!mem_we && $stable(mem_addr)));

    a_r2_fetch_reads: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_F1 || phase == PH_F2) |-> !mem_we);

    a_r2_second_byte: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_F1) |=> (mem_addr == $past(mem_addr) + 1'b1));

    a_r10_write_slot: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_MEM));
endmodule

bind nib_core nib_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .halted   (halted),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .phase    (phase)
);

// File: tb/nib_core_tb.sv
`timescale 1ns/1ps
module nib_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, dbg_val;
    logic       mem_we, halted;
    logic [3:0] dbg_sel = '0;
    logic [7:0] mem [256];
    logic [15:0] expq [$];
    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    nib_core u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
        .dbg_sel(dbg_sel), .dbg_val(dbg_val)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every write must match the next expected {addr,data}
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6/R7/R9 unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = expq.pop_front();
                check({mem_addr, mem_wdata} == e, "R6/R7 write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic expect_write(input logic [7:0] a, input logic [7:0] d);
        expq.push_back({a, d});
    endtask

    task automatic load_prog_start();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] b0, input logic [7:0] b1);
        mem[a] = b0;
        mem[a + 8'd1] = b1;
    endtask

    task automatic run(output int n, output logic [7:0] a0, output logic [7:0] a1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        a0 = mem_addr;
        check(!halted && !mem_we, "R1 start", {halted, mem_we}, 0);
        n = 0;
        a1 = '0;
        for (int k = 0; k < 500; k++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 1) a1 = mem_addr;
            if (halted) break;
        end
    endtask

    task automatic check_reg(input int idx, input logic [7:0] exp, input string req);
        dbg_sel = idx[3:0];
        #1;
        check(dbg_val == exp, req, dbg_val, exp);
    endtask

    initial begin
        int n;
        logic [7:0] a0, a1, hold_addr;

        // ---------- Program A: data movement and arithmetic ----------
        load_prog_start();
        for (int r = 0; r < 16; r++) check_reg(r, 8'h00, "R1 reset reg / R11");
        #1 check(mem_addr == 8'h00 && !mem_we, "R1 addr in reset", mem_addr, 0);
        put(8'd0,  8'h31, 8'h05);   // LI  R1,5      R3
        put(8'd2,  8'h32, 8'hFE);   // LI  R2,FE
        put(8'd4,  8'h41, 8'h20);   // ADD R1,R2 -> 03  R4 wrap
        put(8'd6,  8'h52, 8'h10);   // SUB R2,R1 -> FB
        put(8'd8,  8'h11, 8'h80);   // ST  R1 -> [80]  R6
        put(8'd10, 8'h03, 8'h90);   // LD  R3 <- [90]  R5
        put(8'd12, 8'h34, 8'h81);   // LI  R4,81
        put(8'd14, 8'h24, 8'h30);   // STI [R4] <- R3  R7
        put(8'd16, 8'h55, 8'h20);   // SUB R5,R2 -> 05 R4 borrow wrap
        put(8'd18, 8'hF0, 8'h00);   // undefined -> halt
        mem[8'h90] = 8'h5A;
        expect_write(8'h80, 8'h03);
        expect_write(8'h81, 8'h5A);
        run(n, a0, a1);
        check(a0 == 8'h00, "R1 first fetch addr", a0, 0);
        check(a1 == 8'h01, "R2 second byte addr", a1, 1);
        check(halted, "R9 halted A", halted, 1);
        check(n == 33, "R10 cycles A", n, 33);
        check_reg(1, 8'h03, "R4 add wrap");
        check_reg(2, 8'hFB, "R4 sub");
        check_reg(3, 8'h5A, "R5 load");
        check_reg(4, 8'h81, "R3 immediate");
        check_reg(5, 8'h05, "R4 sub wrap");
        check_reg(0, 8'h00, "R11 untouched reg");
        check(mem[8'h80] == 8'h03, "R6 stored byte", mem[8'h80], 8'h03);
        check(mem[8'h81] == 8'h5A, "R7 stored byte", mem[8'h81], 8'h5A);
        check(expq.size() == 0, "R6 R7 writes seen", expq.size(), 0);

        // ---------- Program B: branches ----------
        load_prog_start();
        put(8'd0,  8'h31, 8'h07);   // LI R1,7
        put(8'd2,  8'h80, 8'h06);   // BZ R0,+6 taken -> 10
        put(8'd4,  8'h32, 8'hAA);   // LI R2,AA (reached by backward branch)
        put(8'd6,  8'hF0, 8'h00);   // halt
        put(8'd8,  8'h11, 8'h40);   // ST (must not run)
        put(8'd10, 8'h81, 8'h02);   // BZ R1 not taken -> 12
        put(8'd12, 8'h33, 8'h11);   // LI R3,11
        put(8'd14, 8'h84, 8'hF4);   // BZ R4,-12 taken -> 4
        run(n, a0, a1);
        check(n == 21, "R8 R10 branch path cycles", n, 21);
        check_reg(1, 8'h07, "R8 pre-branch");
        check_reg(2, 8'hAA, "R8 backward target ran");
        check_reg(3, 8'h11, "R8 not-taken fallthrough");
        check(expq.size() == 0, "R8 skipped store", expq.size(), 0);

        // ---------- Program C: undefined opcode halts ----------
        load_prog_start();
        put(8'd0, 8'h31, 8'h09);    // LI R1,9
        put(8'd2, 8'h61, 8'h00);    // opcode 6: undefined
        put(8'd4, 8'h31, 8'h55);    // must not run
        put(8'd6, 8'h11, 8'h40);    // must not run
        run(n, a0, a1);
        check(n == 6, "R9 R10 halt timing", n, 6);
        hold_addr = mem_addr;
        repeat (20) @(negedge clk);
        check(halted, "R9 halt sticky", halted, 1);
        check(mem_addr == hold_addr, "R9 address held", mem_addr, hold_addr);
        check_reg(1, 8'h09, "R9 no register change");
        check(mem[8'h40] == 8'h00, "R9 no write", mem[8'h40], 0);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!halted, "R1 reset clears halt", halted, 0);
        check_reg(1, 8'h00, "R1 reset clears reg");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule